// File: doc/BRIEF.md
# SPI Serial EEPROM Responder

This block sits on the device side of an SPI bus in mode 0 and answers like a small serial EEPROM. Its purpose is to give a host-side SPI controller a target to test against. Each transaction runs while chip select is low. The first byte is a command code. Memory commands follow it with an address of `ADDR_BYTES` bytes, sent most significant byte first. After that the block either returns data on `spi_miso` or takes data from `spi_mosi`.

The storage is a plain byte array inside the block. Reset fills every byte with 0xFF. A status byte holds a write-enable latch, a busy flag and three protection bits that software can store. Programming commands are accepted only while the latch is set. When chip select rises at the end of a program command, the busy flag stays set for `WRITE_CYCLES` clock cycles. While it is set the block ignores every command except status read. When the busy period ends, the latch clears. Program data wraps inside the page of `PAGE_BYTES` bytes that was addressed. Reads run on across the whole array.

The SPI pins are brought into the `clk` domain through synchronisers. `spi_sck` must therefore stay in each level for several `clk` cycles. The bench holds each level for 8 cycles.

Top module: `spi_eeprom_resp`

## Requirements
- R1: After reset the status byte reads 0x00 and every memory byte reads 0xFF.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. Command 0x05 returns the status byte on every following byte. In that byte, bit 0 is busy, bit 1 is the latch, bits 2 and 3 are the two block-protect bits and bit 7 is protect-enable. Bits 4 to 6 read 0.
- R3: Command 0x03, followed by the address, returns the byte at that address and then the following bytes for as long as chip select stays low. The address wraps from the top of the array to 0.
- R4: With `NINE_BIT`=1 and one address byte, bit 3 of the read or write command carries address bit 8. The read command is then 0x0B and the write command is 0x0A for the upper 256 bytes.
- R5: Command 0x02, followed by the address, stores each complete data byte. The offset inside the `PAGE_BYTES` page advances after each byte and wraps back to the start of the same page.
- R6: A write command or a status-write command given while the latch is clear changes no memory byte and no status bit, and does not set busy.
- R7: Chip select rising after a write or status-write that carried at least one full data byte sets busy for exactly `WRITE_CYCLES` clock cycles. Busy is never set while chip select is low. The latch reads 0 once busy clears.
- R8: While busy is set, every command other than 0x05 is ignored. Memory and the latch keep their values, and `spi_miso` stays 0.
- R9: Command 0x01 with the latch set takes its first data byte into status bits 7, 3 and 2 when chip select rises. The other bits of that data byte have no effect. The command also starts a busy period.
- R10: A command code that is not defined is ignored for the rest of the transaction. Status and memory keep their values, and `spi_miso` stays 0.
- R11: `spi_miso` changes only after falling `spi_sck` edges. It is 0 during the command and address bytes, and it is held 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idles low (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host, sampled on rising `spi_sck` |
| spi_miso | output | 1 | Serial data to the host, updated after falling `spi_sck` |

## Verification
The assertions check several rules on every cycle:
- a memory store never happens while the latch is clear or while busy is set;
- busy only starts with chip select high, and it lasts exactly `WRITE_CYCLES` cycles;
- the latch is clear when busy falls;
- all stores within one transaction land in a single page;
- `spi_miso` is low after chip select goes inactive.

Only the bench scenarios can show that the data sent back is correct. That covers sequential reads that wrap at the top of the array, page wrap as seen by a later read, the effect of the address bit taken from the command code, and the status value before, during and after a program cycle. The bench compares every received byte with a behavioural model of the array and the status byte.

// File: rtl/eeprom_resp_pkg.sv
package eeprom_resp_pkg;

    // command codes
    localparam logic [7:0] CMD_WEN_SET = 8'h06;
    localparam logic [7:0] CMD_WEN_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_RD = 8'h05;
    localparam logic [7:0] CMD_STAT_WR = 8'h01;
    localparam logic [7:0] CMD_MEM_RD  = 8'h03;
    localparam logic [7:0] CMD_MEM_WR  = 8'h02;
    localparam logic [7:0] CMD_A8_BIT  = 8'h08;

    // status byte bit positions
    localparam int SB_BUSY = 0;
    localparam int SB_WEL  = 1;
    localparam int SB_BP0  = 2;
    localparam int SB_BP1  = 3;
    localparam int SB_PEN  = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        DK_MEMRD,
        DK_MEMWR,
        DK_STATRD,
        DK_STATWR
    } dkind_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_end,
    output logic mosi_s
);

    logic [STAGES:0]   sck_sh;
    logic [STAGES:0]   csn_sh;
    logic [STAGES-1:0] mosi_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sh  <= '0;
            csn_sh  <= '1;
            mosi_sh <= '0;
        end else begin
            sck_sh  <= {sck_sh[STAGES-1:0], sck_i};
            csn_sh  <= {csn_sh[STAGES-1:0], cs_n_i};
            mosi_sh <= {mosi_sh[STAGES-2:0], mosi_i};
        end
    end

    assign sck_rise = sck_sh[STAGES-1] & ~sck_sh[STAGES];
    assign sck_fall = ~sck_sh[STAGES-1] & sck_sh[STAGES];
    assign cs_act   = ~csn_sh[STAGES-1];
    assign cs_end   = csn_sh[STAGES-1] & ~csn_sh[STAGES];
    assign mosi_s   = mosi_sh[STAGES-1];

endmodule

// File: rtl/eeprom_byte_array.sv
module eeprom_byte_array #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'hFF;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine
    import eeprom_resp_pkg::*;
#(
    parameter int ADDR_BYTES   = 1,
    parameter bit NINE_BIT     = 1'b1,
    parameter int MEM_DEPTH    = 512,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 2000,
    localparam int AW    = $clog2(MEM_DEPTH),
    localparam int ABITS = 8 * ADDR_BYTES,
    localparam int EXT_W = (ABITS + 1 > AW) ? ABITS + 1 : AW,
    localparam int CW    = $clog2(WRITE_CYCLES + 1),
    localparam int ABCW  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          cs_act,
    input  logic          cs_end,
    input  logic          mosi_s,
    input  logic [7:0]    mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic          miso,
    output logic          busy,
    output logic          wel
);

    localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);

    typedef struct packed {
        phase_e          phase;
        dkind_e          kind;
        logic [2:0]      bitcnt;
        logic [7:0]      rx;
        logic            cmd_b3;
        logic [ABCW-1:0] abyte;
        logic [ABITS-1:0] acc;
        logic [AW-1:0]   addr;
        logic [7:0]      tx;
        logic            miso;
        logic            wel;
        logic [1:0]      bp;
        logic            pen;
        logic [CW-1:0]   busy_cnt;
        logic            prog_pend;
        logic            sr_pend;
        logic [7:0]      sr_val;
    } eng_state_t;

    eng_state_t q, d;

    logic [7:0]       rx_byte;
    logic [ABITS-1:0] acc_n;
    logic [EXT_W-1:0] ext;
    logic [AW-1:0]    full_addr;
    logic [7:0]       status_b;
    logic             busy_now;
    logic             is_rd_cmd;
    logic             is_wr_cmd;

    assign busy_now = (q.busy_cnt != '0);
    assign rx_byte  = {q.rx[6:0], mosi_s};
    assign acc_n    = (q.acc << 8) | ABITS'(rx_byte);

    always_comb begin
        ext = EXT_W'(acc_n);
        if (NINE_BIT) begin
            ext[ABITS] = q.cmd_b3;
        end
    end
    assign full_addr = ext[AW-1:0];

    always_comb begin
        status_b          = '0;
        status_b[SB_BUSY] = busy_now;
        status_b[SB_WEL]  = q.wel;
        status_b[SB_BP0]  = q.bp[0];
        status_b[SB_BP1]  = q.bp[1];
        status_b[SB_PEN]  = q.pen;
    end

    always_comb begin
        is_rd_cmd = (rx_byte == CMD_MEM_RD) ||
                    (NINE_BIT && rx_byte == (CMD_MEM_RD | CMD_A8_BIT));
        is_wr_cmd = (rx_byte == CMD_MEM_WR) ||
                    (NINE_BIT && rx_byte == (CMD_MEM_WR | CMD_A8_BIT));
    end

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_waddr = q.addr;
        mem_wdata = rx_byte;
        mem_raddr = q.addr;

        // program-cycle countdown
        if (busy_now) begin
            d.busy_cnt = q.busy_cnt - CW'(1);
            if (q.busy_cnt == CW'(1)) begin
                d.wel = 1'b0;
            end
        end

        if (!cs_act) begin
            d.phase  = PH_IDLE;
            d.bitcnt = '0;
            d.tx     = '0;
            d.miso   = 1'b0;
            if (cs_end) begin
                if (q.prog_pend) begin
                    d.busy_cnt = CW'(WRITE_CYCLES);
                end
                if (q.sr_pend) begin
                    d.pen   = q.sr_val[SB_PEN];
                    d.bp[1] = q.sr_val[SB_BP1];
                    d.bp[0] = q.sr_val[SB_BP0];
                end
                d.prog_pend = 1'b0;
                d.sr_pend   = 1'b0;
            end
        end else if (q.phase == PH_IDLE) begin
            d.phase  = PH_CMD;
            d.bitcnt = '0;
            d.abyte  = '0;
            d.acc    = '0;
        end else begin
            if (sck_fall) begin
                d.miso = q.tx[7];
                d.tx   = {q.tx[6:0], 1'b0};
            end
            if (sck_rise) begin
                d.rx     = rx_byte;
                d.bitcnt = q.bitcnt + 3'd1;
                if (q.bitcnt == 3'd7) begin
                    unique case (q.phase)
                        PH_CMD: begin
                            d.cmd_b3 = rx_byte[3];
                            d.phase  = PH_SKIP;
                            if (busy_now) begin
                                if (rx_byte == CMD_STAT_RD) begin
                                    d.phase = PH_DATA;
                                    d.kind  = DK_STATRD;
                                    d.tx    = status_b;
                                end
                            end else if (rx_byte == CMD_WEN_SET) begin
                                d.wel = 1'b1;
                            end else if (rx_byte == CMD_WEN_CLR) begin
                                d.wel = 1'b0;
                            end else if (rx_byte == CMD_STAT_RD) begin
                                d.phase = PH_DATA;
                                d.kind  = DK_STATRD;
                                d.tx    = status_b;
                            end else if (rx_byte == CMD_STAT_WR) begin
                                if (q.wel) begin
                                    d.phase = PH_DATA;
                                    d.kind  = DK_STATWR;
                                end
                            end else if (is_rd_cmd) begin
                                d.phase = PH_ADDR;
                                d.kind  = DK_MEMRD;
                            end else if (is_wr_cmd) begin
                                if (q.wel) begin
                                    d.phase = PH_ADDR;
                                    d.kind  = DK_MEMWR;
                                end
                            end
                        end
                        PH_ADDR: begin
                            d.acc   = acc_n;
                            d.abyte = q.abyte + ABCW'(1);
                            if (q.abyte == ABCW'(ADDR_BYTES - 1)) begin
                                d.phase = PH_DATA;
                                if (q.kind == DK_MEMRD) begin
                                    mem_raddr = full_addr;
                                    d.tx      = mem_rdata;
                                    d.addr    = full_addr + AW'(1);
                                end else begin
                                    d.addr = full_addr;
                                end
                            end
                        end
                        PH_DATA: begin
                            unique case (q.kind)
                                DK_MEMRD: begin
                                    d.tx   = mem_rdata;
                                    d.addr = q.addr + AW'(1);
                                end
                                DK_STATRD: begin
                                    d.tx = status_b;
                                end
                                DK_MEMWR: begin
                                    mem_we      = 1'b1;
                                    d.addr      = (q.addr & ~PMASK) |
                                                  ((q.addr + AW'(1)) & PMASK);
                                    d.prog_pend = 1'b1;
                                end
                                DK_STATWR: begin
                                    if (!q.sr_pend) begin
                                        d.sr_val    = rx_byte;
                                        d.sr_pend   = 1'b1;
                                        d.prog_pend = 1'b1;
                                    end
                                end
                                default: ;
                            endcase
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, kind: DK_MEMRD, default: '0};
        end else begin
            q <= d;
        end
    end

    assign miso = q.miso;
    assign busy = busy_now;
    assign wel  = q.wel;

endmodule

// File: rtl/spi_eeprom_resp.sv
module spi_eeprom_resp #(
    parameter int ADDR_BYTES   = 1,
    parameter bit NINE_BIT     = 1'b1,
    parameter int MEM_DEPTH    = 512,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 2000,
    parameter int SYNC_STAGES  = 2,
    localparam int AW = $clog2(MEM_DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);

    logic          sck_rise;
    logic          sck_fall;
    logic          cs_act;
    logic          cs_end;
    logic          mosi_s;
    logic [7:0]    mem_rdata;
    logic [AW-1:0] mem_raddr;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata;
    logic          busy;
    logic          wel;

    spi_pin_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_i   (spi_sck),
        .cs_n_i  (spi_cs_n),
        .mosi_i  (spi_mosi),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .cs_act  (cs_act),
        .cs_end  (cs_end),
        .mosi_s  (mosi_s)
    );

    eeprom_cmd_engine #(
        .ADDR_BYTES  (ADDR_BYTES),
        .NINE_BIT    (NINE_BIT),
        .MEM_DEPTH   (MEM_DEPTH),
        .PAGE_BYTES  (PAGE_BYTES),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .cs_end   (cs_end),
        .mosi_s   (mosi_s),
        .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata),
        .miso     (spi_miso),
        .busy     (busy),
        .wel      (wel)
    );

    eeprom_byte_array #(
        .DEPTH(MEM_DEPTH)
    ) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

endmodule

// File: rtl/spi_eeprom_resp_chk.sv
module spi_eeprom_resp_chk #(
    parameter int AW           = 9,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 2000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_act,
    input logic          busy,
    input logic          wel,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr,
    input logic          spi_miso
);

    localparam int PB = $clog2(PAGE_BYTES);

    logic [31:0]   busy_len;
    logic          seen_wr;
    logic [AW-1:0] page_of_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len   <= '0;
            seen_wr    <= 1'b0;
            page_of_wr <= '0;
        end else begin
            busy_len <= busy ? busy_len + 32'd1 : 32'd0;
            if (!cs_act) begin
                seen_wr <= 1'b0;
            end else if (mem_we) begin
                seen_wr    <= 1'b1;
                page_of_wr <= mem_waddr >> PB;
            end
        end
    end

    assert_store_needs_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    assert_no_store_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !busy);

    assert_busy_starts_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !cs_act);

    assert_latch_clear_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == 32'(WRITE_CYCLES)));

    assert_stores_in_one_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && seen_wr) |-> ((mem_waddr >> PB) == page_of_wr));

    assert_miso_low_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso);

endmodule

bind spi_eeprom_resp spi_eeprom_resp_chk #(
    .AW          (AW),
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .busy     (busy),
    .wel      (wel),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .spi_miso (spi_miso)
);

// File: tb/spi_eeprom_resp_test.sv
`timescale 1ns/1ps
module spi_eeprom_resp_test;

    localparam int W_CYC = 4000;
    localparam int HALF  = 8;
    localparam int DEPTH = 512;
    localparam int PAGE  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    always #4 clk = ~clk;

    spi_eeprom_resp #(
        .ADDR_BYTES  (1),
        .NINE_BIT    (1'b1),
        .MEM_DEPTH   (DEPTH),
        .PAGE_BYTES  (PAGE),
        .WRITE_CYCLES(W_CYC)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .spi_sck (sck),
        .spi_cs_n(cs_n),
        .spi_mosi(mosi),
        .spi_miso(miso)
    );

    // reference model
    logic [7:0] m_mem [DEPTH];
    logic       m_wel = 1'b0;
    logic [1:0] m_bp = 2'b00;
    logic       m_pen = 1'b0;
    int         busy_left = 0;

    logic [7:0] tx_b [64];
    logic [7:0] rx_b [64];
    logic [7:0] wr_b [64];

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors + 1, fails + 1);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy_left > 0) begin
                busy_left = busy_left - 1;
                if (busy_left == 0) m_wel = 1'b0;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int n);
        wait_clk(1);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                mosi = tx_b[i][b];
                wait_clk(HALF);
                rx_b[i][b] = miso;
                sck = 1'b1;
                wait_clk(HALF);
                sck = 1'b0;
            end
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(3 * HALF);
    endtask

    function automatic logic [7:0] m_status();
        return {m_pen, 3'b000, m_bp, m_wel, (busy_left > 0)};
    endfunction

    task automatic do_simple(input logic [7:0] op, input string tag);
        tx_b[0] = op;
        xfer(1);
        chk({tag, " R11 miso low in command"}, rx_b[0], 8'h00);
        if (busy_left == 0) begin
            if (op == 8'h06) m_wel = 1'b1;
            if (op == 8'h04) m_wel = 1'b0;
        end
    endtask

    task automatic do_rdsr(input int n, input string tag);
        logic [7:0] e;
        e = m_status();
        tx_b[0] = 8'h05;
        for (int i = 1; i <= n; i++) tx_b[i] = 8'hA5;
        xfer(n + 1);
        chk({tag, " R11 miso low in command"}, rx_b[0], 8'h00);
        for (int i = 1; i <= n; i++) chk({tag, " status"}, rx_b[i], e);
    endtask

    task automatic do_read(input int addr, input int n, input string tag);
        bit blocked;
        blocked = (busy_left > 0);
        tx_b[0] = 8'h03 | ((addr >= 256) ? 8'h08 : 8'h00);
        tx_b[1] = 8'(addr);
        for (int i = 0; i < n; i++) tx_b[i + 2] = 8'h5A;
        xfer(n + 2);
        chk({tag, " R11 miso low in command"}, rx_b[0], 8'h00);
        chk({tag, " R11 miso low in address"}, rx_b[1], 8'h00);
        for (int i = 0; i < n; i++) begin
            chk({tag, " data"}, rx_b[i + 2],
                blocked ? 8'h00 : m_mem[(addr + i) % DEPTH]);
        end
    endtask

    task automatic do_write(input int addr, input int n, input string tag);
        tx_b[0] = 8'h02 | ((addr >= 256) ? 8'h08 : 8'h00);
        tx_b[1] = 8'(addr);
        for (int i = 0; i < n; i++) tx_b[i + 2] = wr_b[i];
        xfer(n + 2);
        chk({tag, " R11 miso low during write"}, rx_b[1], 8'h00);
        if (busy_left == 0 && m_wel && n > 0) begin
            for (int i = 0; i < n; i++) begin
                m_mem[(addr & ~(PAGE - 1)) | ((addr + i) % PAGE)] = wr_b[i];
            end
            busy_left = W_CYC;
        end
    endtask

    task automatic do_wrsr(input logic [7:0] v, input string tag);
        tx_b[0] = 8'h01;
        tx_b[1] = v;
        xfer(2);
        chk({tag, " R11 miso low during status write"}, rx_b[1], 8'h00);
        if (busy_left == 0 && m_wel) begin
            m_pen = v[7];
            m_bp  = v[3:2];
            busy_left = W_CYC;
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(10);

        // R1: reset state
        do_rdsr(2, "R1 reset status");
        do_read(12'h1F0, 8, "R1 reset memory upper");
        do_read(0, 4, "R1 reset memory lower");

        // R6: write without latch
        for (int i = 0; i < 3; i++) wr_b[i] = 8'h11 + 8'(i);
        do_write(16, 3, "R6 write no latch");
        do_rdsr(1, "R6 no busy after rejected write");
        do_read(16, 3, "R6 memory unchanged");
        do_wrsr(8'hFF, "R6 status write no latch");
        do_rdsr(1, "R6 status unchanged");

        // R2: latch set and clear
        do_simple(8'h06, "R2 set latch");
        do_rdsr(2, "R2 latch set");
        do_simple(8'h04, "R2 clear latch");
        do_rdsr(1, "R2 latch clear");

        // R5/R7: page-wrapping write then busy
        do_simple(8'h06, "R5 set latch");
        for (int i = 0; i < 6; i++) wr_b[i] = 8'hA0 + 8'(i);
        do_write(12, 6, "R5 wrapping write");
        do_rdsr(2, "R7 busy during program");

        // R8: commands ignored while busy
        do_simple(8'h04, "R8 clear latch while busy");
        for (int i = 0; i < 3; i++) wr_b[i] = 8'h33;
        do_write(12'h100, 3, "R8 write while busy");
        do_read(0, 4, "R8 read while busy");
        do_simple(8'hAB, "R8 unknown while busy");
        do_rdsr(1, "R8 latch kept while busy");

        wait_clk(W_CYC + 100);
        do_rdsr(1, "R7 busy cleared and latch cleared");
        do_read(0, 20, "R5 R3 readback after wrap");
        do_read(12'h100, 4, "R8 blocked write left memory");

        // R4: upper half through command bit 3, page and array wrap
        do_simple(8'h06, "R4 set latch");
        for (int i = 0; i < 4; i++) wr_b[i] = 8'hC0 + 8'(i);
        do_write(12'h1FE, 4, "R4 upper write");
        wait_clk(W_CYC + 100);
        do_read(12'h1FC, 8, "R4 R3 read across top of array");
        do_read(12'h1F0, 3, "R4 R5 upper page wrap");

        // R9: status write
        do_simple(8'h06, "R9 set latch");
        do_wrsr(8'hFF, "R9 status write");
        do_rdsr(1, "R9 status during program");
        wait_clk(W_CYC + 100);
        do_rdsr(2, "R9 status after program");
        do_simple(8'h06, "R9 set latch again");
        do_wrsr(8'h73, "R9 status write partial");
        wait_clk(W_CYC + 100);
        do_rdsr(1, "R9 status masked bits");

        // R10: undefined command
        do_simple(8'h06, "R10 set latch");
        tx_b[0] = 8'hAB; tx_b[1] = 8'h00; tx_b[2] = 8'hFF;
        xfer(3);
        chk("R10 undefined command miso byte1", rx_b[1], 8'h00);
        chk("R10 undefined command miso byte2", rx_b[2], 8'h00);
        do_rdsr(1, "R10 status unchanged");
        tx_b[0] = 8'h0A; tx_b[1] = 8'h00;
        do_simple(8'h04, "R10 clear latch");
        do_read(12'h1FE, 2, "R10 memory unchanged");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule